// File: doc/BRIEF.md
# Storage Request Latency Emulator

This block stands in for a solid-state storage device when only its timing matters. A host offers one I/O request descriptor at a time (starting block, length in KB, read or write) over a valid/ready handshake. The block compares the descriptor with the one it accepted before and calls it sequential or random. It picks one of four programmable coefficient pairs from that class and the direction. It then computes a service time in microsecond ticks as intercept plus length times slope. It holds `busy` for that many ticks and then pulses `done`.

No data is stored, and only one request is outstanding at a time. The only history kept is the last accepted descriptor. A prescaler input sets how many clock cycles make one tick. A small write port lets software replace any coefficient pair between requests.

Top module: `lat_emu`

## Requirements
- R1: After reset `reqReady` is 1, and `busy` and `done` are 0.
- R2: The first request accepted after reset is always treated as random.
- R3: A request is sequential when its block equals the previous block plus the previous length (modulo 2^BLK_W) and its write flag equals the previous one. Otherwise it is random.
- R4: A request that is address-contiguous but reverses direction (read after write, or write after read) is random.
- R5: Coefficients are unsigned Q.10 (value × 1024). Pair index is {write, random}: 0 sequential read, 1 random read, 2 sequential write, 3 random write. The reset pairs are 127.5/4.005, 230.6/3.987, 2167/4.96 and 770/5.382 µs, µs/KB, stored rounded to the nearest 1/1024. Ticks = floor((A + len·B + 512) / 1024).
- R6: `busy` stays high for exactly ticks × D consecutive cycles starting the cycle after acceptance. D is `tickDiv`, and a value of 0 acts as 1.
- R7: `done` is a one-cycle pulse in the cycle right after `busy` falls. In that cycle `busy` is 0 and `reqReady` is 1. `reqReady` is 1 exactly when `busy` is 0.
- R8: A request whose tick count is 0 raises no `busy` and pulses `done` in the cycle after acceptance.
- R9: A write with `cfgWe` replaces the pair picked by `cfgSel` (encoded as in R5). The new pair applies to every request accepted afterwards.
- R10: `reqValid` asserted while `busy` is ignored. Nothing is accepted, and the stored previous descriptor is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request descriptor offered |
| reqReady | output | 1 | Emulator idle, can accept |
| reqBlock | input | BLK_W | Starting block number |
| reqLen | input | LEN_W | Length in KB |
| reqWrite | input | 1 | 1 = write, 0 = read |
| cfgWe | input | 1 | Coefficient write strobe |
| cfgSel | input | 2 | Pair index {write, random} |
| cfgIntercept | input | COEF_W | Intercept A, Q.10 µs |
| cfgSlope | input | COEF_W | Slope B, Q.10 µs/KB |
| tickDiv | input | DIV_W | Clock cycles per µs tick (0 acts as 1) |
| busy | output | 1 | Service time in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a request whose tick count rounds to exactly zero, and its neighbour that rounds to exactly one. The reset coefficients never yield zero ticks. To get there, the stimulus rewrites the random-read pair to intercept 511/1024 with zero slope, then to 512/1024. Each setting is followed by a non-contiguous read. The other hard case is a descriptor offered while busy, which must leave the stored history untouched. The bench holds a bogus request on the handshake through a long busy window, then proves the stored descriptor is intact: the next contiguous read must still be classified sequential.

// File: rtl/lat_emu_pkg.sv
package lat_emu_pkg;

  localparam int FRAC_BITS = 10;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } ctlState_t;

  // control -> datapath
  typedef struct packed {
    logic accept;  // capture descriptor, load countdown
    logic run;     // advance prescaler/countdown
  } ctlStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic zeroDelay;  // computed tick count of offered request is 0
    logic lastTick;   // countdown reaches zero this cycle
  } dpStatus_t;

  // reset coefficients, Q.10, index {write, random}
  function automatic logic [31:0] resetIntercept(input int idx);
    case (idx)
      0:       return 32'd130560;   // 127.5
      1:       return 32'd236134;   // 230.6
      2:       return 32'd2219008;  // 2167
      default: return 32'd788480;   // 770
    endcase
  endfunction

  function automatic logic [31:0] resetSlope(input int idx);
    case (idx)
      0:       return 32'd4101;  // 4.005
      1:       return 32'd4083;  // 3.987
      2:       return 32'd5079;  // 4.96
      default: return 32'd5511;  // 5.382
    endcase
  endfunction

endpackage

// File: rtl/lat_emu_dp.sv
module lat_emu_dp
  import lat_emu_pkg::*;
#(
  parameter int BLK_W  = 32,
  parameter int LEN_W  = 16,
  parameter int COEF_W = 23,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [BLK_W-1:0]  reqBlock,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqWrite,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [COEF_W-1:0] cfgIntercept,
  input  logic [COEF_W-1:0] cfgSlope,
  input  logic [DIV_W-1:0]  tickDiv,
  output dpStatus_t         status
);

  localparam int ACC_W   = LEN_W + COEF_W + 1;
  localparam int CNT_W   = ACC_W - FRAC_BITS;
  localparam int N_PAIRS = 4;

  logic [COEF_W-1:0] coefA [N_PAIRS];
  logic [COEF_W-1:0] coefB [N_PAIRS];

  logic              prevValid;
  logic [BLK_W-1:0]  prevBlock;
  logic [LEN_W-1:0]  prevLen;
  logic              prevWrite;

  logic [CNT_W-1:0]  tickCnt;
  logic [DIV_W-1:0]  preCnt;

  logic              isSeq;
  logic [1:0]        pairSel;
  logic [ACC_W-1:0]  acc;
  logic [CNT_W-1:0]  ticks;
  logic [DIV_W-1:0]  divLast;
  logic              preWrap;

  // classification against the stored descriptor
  always_comb begin
    isSeq   = prevValid
           && (reqBlock == BLK_W'(prevBlock + BLK_W'(prevLen)))
           && (reqWrite == prevWrite);
    pairSel = {reqWrite, ~isSeq};
  end

  // linear model, rounded to whole ticks
  always_comb begin
    acc   = ACC_W'(coefA[pairSel])
          + (ACC_W'(reqLen) * ACC_W'(coefB[pairSel]))
          + ACC_W'(1 << (FRAC_BITS - 1));
    ticks = acc[ACC_W-1:FRAC_BITS];
  end

  always_comb begin
    divLast = (tickDiv == '0) ? '0 : DIV_W'(tickDiv - 1'b1);
    preWrap = (preCnt == divLast);
    status.zeroDelay = (ticks == '0);
    status.lastTick  = strobes.run && preWrap && (tickCnt == CNT_W'(1));
  end

  // coefficient registers
  generate
    for (genvar g = 0; g < N_PAIRS; g++) begin : gPair
      always_ff @(posedge clk) begin
        if (!rstN) begin
          coefA[g] <= COEF_W'(resetIntercept(g));
          coefB[g] <= COEF_W'(resetSlope(g));
        end else if (cfgWe && (cfgSel == 2'(g))) begin
          coefA[g] <= cfgIntercept;
          coefB[g] <= cfgSlope;
        end
      end
    end
  endgenerate

  // previous-request record
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevValid <= 1'b0;
      prevBlock <= '0;
      prevLen   <= '0;
      prevWrite <= 1'b0;
    end else if (strobes.accept) begin
      prevValid <= 1'b1;
      prevBlock <= reqBlock;
      prevLen   <= reqLen;
      prevWrite <= reqWrite;
    end
  end

  // prescaler and countdown
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
      preCnt  <= '0;
    end else if (strobes.accept) begin
      tickCnt <= ticks;
      preCnt  <= '0;
    end else if (strobes.run) begin
      if (preWrap) begin
        preCnt  <= '0;
        tickCnt <= tickCnt - 1'b1;
      end else begin
        preCnt  <= preCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lat_emu_ctl.sv
module lat_emu_ctl
  import lat_emu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  dpStatus_t   status,
  output ctlStrobes_t strobes,
  output logic        reqReady,
  output logic        busy,
  output logic        done
);

  ctlState_t state;

  always_comb begin
    reqReady       = (state == ST_IDLE);
    busy           = (state == ST_BUSY);
    strobes.accept = reqValid && reqReady;
    strobes.run    = busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (strobes.accept) begin
            if (status.zeroDelay) done  <= 1'b1;
            else                  state <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (status.lastTick) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lat_emu.sv
module lat_emu
  import lat_emu_pkg::*;
#(
  parameter int BLK_W  = 32,
  parameter int LEN_W  = 16,
  parameter int COEF_W = 23,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [BLK_W-1:0]  reqBlock,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqWrite,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [COEF_W-1:0] cfgIntercept,
  input  logic [COEF_W-1:0] cfgSlope,
  input  logic [DIV_W-1:0]  tickDiv,
  output logic              busy,
  output logic              done
);

  ctlStrobes_t strobes;
  dpStatus_t   status;

  lat_emu_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .status   (status),
    .strobes  (strobes),
    .reqReady (reqReady),
    .busy     (busy),
    .done     (done)
  );

  lat_emu_dp #(
    .BLK_W  (BLK_W),
    .LEN_W  (LEN_W),
    .COEF_W (COEF_W),
    .DIV_W  (DIV_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .reqBlock     (reqBlock),
    .reqLen       (reqLen),
    .reqWrite     (reqWrite),
    .cfgWe        (cfgWe),
    .cfgSel       (cfgSel),
    .cfgIntercept (cfgIntercept),
    .cfgSlope     (cfgSlope),
    .tickDiv      (tickDiv),
    .status       (status)
  );

endmodule

// File: rtl/lat_emu_chk.sv
module lat_emu_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic busy,
  input logic done
);

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && reqReady)); // R7

  AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R7

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done)); // R6

  AST_BUSY_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid && reqReady)); // R10

  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy || (reqValid && reqReady))); // R8

endmodule

bind lat_emu lat_emu_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .busy     (busy),
  .done     (done)
);

// File: tb/lat_emu_bench.sv
module lat_emu_bench;

  localparam int BLK_W  = 32;
  localparam int LEN_W  = 16;
  localparam int COEF_W = 23;
  localparam int DIV_W  = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [BLK_W-1:0]  reqBlock = '0;
  logic [LEN_W-1:0]  reqLen = '0;
  logic              reqWrite = 1'b0;
  logic              cfgWe = 1'b0;
  logic [1:0]        cfgSel = '0;
  logic [COEF_W-1:0] cfgIntercept = '0;
  logic [COEF_W-1:0] cfgSlope = '0;
  logic [DIV_W-1:0]  tickDiv = 16'd1;
  logic              busy;
  logic              done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  lat_emu u_lat_emu (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqBlock(reqBlock), .reqLen(reqLen), .reqWrite(reqWrite),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgIntercept(cfgIntercept),
    .cfgSlope(cfgSlope), .tickDiv(tickDiv), .busy(busy), .done(done)
  );

  // bench-side coefficient model, Q.10, index {write, random}
  longint mA [4] = '{130560, 236134, 2219008, 788480};
  longint mB [4] = '{4101, 4083, 5079, 5511};

  // blk, len, write, expected sequential
  typedef struct packed {
    logic [31:0] blk;
    logic [15:0] len;
    logic        wr;
    logic        seq;
  } vec_t;

  localparam int N_VEC = 8;
  localparam vec_t VECS [N_VEC] = '{
    '{32'd100, 16'd4,  1'b0, 1'b0},  // R2 first is random
    '{32'd104, 16'd8,  1'b0, 1'b1},  // R3 seq read
    '{32'd112, 16'd2,  1'b1, 1'b0},  // R4 contiguous, dir change
    '{32'd114, 16'd3,  1'b1, 1'b1},  // R3 seq write
    '{32'd200, 16'd1,  1'b1, 1'b0},  // R3 jump -> random write
    '{32'd201, 16'd16, 1'b0, 1'b0},  // R4 write->read
    '{32'd217, 16'd0,  1'b0, 1'b1},  // R5 zero length, intercept only
    '{32'd217, 16'd5,  1'b0, 1'b1}   // R3 after zero length
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runReq(input logic [31:0] blk, input logic [15:0] len,
                        input logic wr, input logic seq, input string req);
    longint expTicks, expCycles, divEff, nBusy;
    int     sel;
    bit     sawDone, overlap;
    sel       = {wr, ~seq};
    expTicks  = (mA[sel] + longint'(len) * mB[sel] + 512) >>> 10;
    divEff    = (tickDiv == 0) ? 1 : longint'(tickDiv);
    expCycles = expTicks * divEff;
    @(negedge clk);
    reqBlock = blk; reqLen = len; reqWrite = wr; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    nBusy = 0; sawDone = 0; overlap = 0;
    for (int i = 0; i < 100000; i++) begin
      if (done) begin
        sawDone = 1;
        if (busy || !reqReady) overlap = 1;
        break;
      end
      if (busy) nBusy++;
      if (reqReady == busy) overlap = 1;
      @(negedge clk);
    end
    chk(sawDone, {req, " R7 done seen"}, sawDone, 1);
    chk(nBusy == expCycles, {req, " R5/R6 busy cycles"}, nBusy, expCycles);
    chk(!overlap, "R7 ready/busy/done relation", overlap, 0);
    @(negedge clk);
    chk(!done, "R7 done is one cycle", done, 0);
  endtask

  task automatic writeCfg(input int sel, input longint a, input longint b);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = 2'(sel);
    cfgIntercept = COEF_W'(a); cfgSlope = COEF_W'(b);
    @(negedge clk);
    cfgWe = 1'b0;
    mA[sel] = a; mB[sel] = b;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(reqReady && !busy && !done, "R1 reset state", {reqReady, busy, done}, 3'b100);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !busy && !done, "R1 after release", {reqReady, busy, done}, 3'b100);

    for (int v = 0; v < N_VEC; v++)
      runReq(VECS[v].blk, VECS[v].len, VECS[v].wr, VECS[v].seq, $sformatf("vec%0d", v));

    // R10: request offered while busy is ignored
    @(negedge clk);
    reqBlock = 300; reqLen = 4; reqWrite = 1'b0; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqBlock = 999; reqLen = 50; reqWrite = 1'b1;
    for (int k = 0; k < 5; k++) begin
      chk(!reqReady && busy, "R10 not ready while busy", reqReady, 0);
      @(negedge clk);
    end
    reqValid = 1'b0;
    for (int i = 0; i < 100000; i++) begin
      if (done) break;
      @(negedge clk);
    end
    @(negedge clk);
    runReq(304, 1, 1'b0, 1'b1, "R10 history intact");

    // R6 prescaler
    tickDiv = 16'd3;
    runReq(305, 2, 1'b0, 1'b1, "R6 div3");
    tickDiv = 16'd0;
    runReq(307, 1, 1'b0, 1'b1, "R6 div0");
    tickDiv = 16'd1;

    // R9 / R8 zero-tick boundary
    writeCfg(1, 511, 0);
    runReq(5000, 7, 1'b0, 1'b0, "R8 R9 zero ticks");
    writeCfg(1, 512, 0);
    runReq(6000, 3, 1'b0, 1'b0, "R9 one tick");
    // R9: other pairs untouched
    runReq(6003, 2, 1'b0, 1'b1, "R9 seq read unchanged");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule